// File: doc/BRIEF.md
# NAND Bus Strobe Timing Engine

This block shapes the control strobes of a parallel NAND flash bus. A 26-bit timing word holds the low and high durations of the write-enable and read-enable pulses, a bus turnaround gap, a delay before the ready/busy line may be sampled after a command, and a delay from chip-enable assertion to the first strobe. Each field is a count of clock cycles, and software derives it from the clock period. Two small configuration registers select the device geometry (large page and four address cycles) and the chip-enable policy.

Writes to the configuration and timing registers are refused unless the unlock key was written to the lock register first. A key arms exactly one later configuration write. Any write to the lock register that carries another value disarms it. A requester asks for a read or a write strobe by holding a level request. The engine sequences chip enable, turnaround, the low phase and the high phase, and it flags completion with a one-cycle done pulse.

Top module: `nand_bus_timer`

## Requirements
- R1: After reset nand_we_n, nand_re_n and nand_ce_n are 1, and strb_done, rb_sample, cfg_large_page and cfg_addr4 are 0.
- R2: A write to a configuration address (1 timing, 2 interface, 3 chip-enable) leaves every register unchanged when the lock is not armed.
- R3: A write of 0x0000A25E to address 0 arms the lock. The next configuration write then takes effect: interface bit 2 drives cfg_large_page, and interface bit 1 drives cfg_addr4.
- R4: An armed lock is used up by one configuration write. A lock write with any other value disarms it.
- R5: strb_req is a level held until strb_done. For a write (strb_rd=0), nand_we_n is low for the write-low count and then high for the write-high count. strb_done is high for a single cycle, the last high cycle, and nand_re_n stays high throughout.
- R6: A read strobe (strb_rd=1) has the same shape on nand_re_n, using the read-low and read-high counts.
- R7: A timing field of value 0 gives one cycle.
- R8: With chip-enable register bit 0 set (normal mode, the reset value), nand_ce_n goes low when a request is accepted while it is high. The first strobe then waits for the chip-enable-to-access count. nand_ce_n returns high once the engine is idle with no request.
- R9: With chip-enable bit 0 cleared, nand_ce_n is held low. A strobe then starts in the cycle after it is accepted.
- R10: A write that follows a read keeps both strobes high for at least the turnaround count of cycles after the read's done cycle. A strobe that follows a write, and a read that follows any strobe, is not delayed by turnaround.
- R11: A write issued with strb_cmd=1 makes rb_sample pulse for one cycle, a busy-delay count of cycles after its done cycle. Plain writes and reads give no pulse.
- R12: Timing word fields: write-low [3:0], write-high [7:4], read-low [11:8], read-high [15:12], turnaround [18:16], busy delay [23:19], chip-enable-to-access [25:24].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address (0 lock, 1 timing, 2 interface, 3 chip-enable) |
| reg_wdata | input | DATA_W | Register write data |
| strb_req | input | 1 | Strobe request, held until strb_done |
| strb_rd | input | 1 | 1 for a read strobe, 0 for a write strobe |
| strb_cmd | input | 1 | Write strobe carries a command; arms the busy-sample delay |
| strb_done | output | 1 | One-cycle completion pulse |
| nand_we_n | output | 1 | Write enable, active low |
| nand_re_n | output | 1 | Read enable, active low |
| nand_ce_n | output | 1 | Chip enable, active low |
| rb_sample | output | 1 | Pulse marking when ready/busy may be sampled |
| cfg_large_page | output | 1 | Large-page device selected |
| cfg_addr4 | output | 1 | Four address cycles selected |

## Verification
The bench targets the unlock window. A design that leaves the key armed would accept a second write, and one that ignores a wrong key would accept a write after it. Both show up at the configuration outputs. Zero fields, the largest fields and the chip-enable lead-in are measured cycle by cycle: an off-by-one counter lengthens or shortens a phase, and treating zero as zero collapses a phase. Back-to-back strobes check that only a read-to-write change pays the turnaround gap, and command versus plain writes check that rb_sample fires only after commands, at the exact cycle.

// File: rtl/nand_tim_pkg.sv
package nand_tim_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CEA,
      ST_TA,
      ST_LOW,
      ST_HIGH
   } tim_state_e;

   // Timing word fields: positions fixed by the software encoding (R12)
   localparam int NUM_FLD = 7;
   localparam int F_WL  = 0;
   localparam int F_WH  = 1;
   localparam int F_RL  = 2;
   localparam int F_RH  = 3;
   localparam int F_TA  = 4;
   localparam int F_BSY = 5;
   localparam int F_CEA = 6;
   localparam int FLD_LSB [NUM_FLD] = '{0, 4, 8, 12, 16, 19, 24};
   localparam int FLD_WID [NUM_FLD] = '{4, 4, 4, 4, 3, 5, 2};
   localparam int TIMING_W = 26;
   localparam int MAX_FLD_W = 5;

   // Register addresses
   localparam int A_LOCK   = 0;
   localparam int A_TIMING = 1;
   localparam int A_IFCFG  = 2;
   localparam int A_CECFG  = 3;

   // Configuration bit positions
   localparam int IF_LARGE_BIT  = 2;
   localparam int IF_ADDR4_BIT  = 1;
   localparam int CE_NORMAL_BIT = 0;

endpackage

// File: rtl/nand_tim_regs.sv
module nand_tim_regs
   import nand_tim_pkg::*;
#(
   parameter int                ADDR_W        = 4,
   parameter int                DATA_W        = 32,
   parameter logic [DATA_W-1:0] KEY           = 32'h0000_A25E,
   parameter logic [DATA_W-1:0] TIMING_RST    = '0,
   parameter bit                CE_NORMAL_RST = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   wr_addr,
   input  logic [DATA_W-1:0]   wr_data,
   output logic [TIMING_W-1:0] timing_q,
   output logic                large_page,
   output logic                addr4,
   output logic                ce_normal
);

   logic armed;
   logic hit_lock, hit_tim, hit_if, hit_ce, hit_cfg;

   assign hit_lock = wr_en && (wr_addr == ADDR_W'(A_LOCK));
   assign hit_tim  = wr_en && (wr_addr == ADDR_W'(A_TIMING));
   assign hit_if   = wr_en && (wr_addr == ADDR_W'(A_IFCFG));
   assign hit_ce   = wr_en && (wr_addr == ADDR_W'(A_CECFG));
   assign hit_cfg  = hit_tim || hit_if || hit_ce;

   // One-shot unlock: a key arms, any config write or bad key disarms
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0;
      end else if (hit_lock) begin
         armed <= (wr_data == KEY);
      end else if (hit_cfg) begin
         armed <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         timing_q   <= TIMING_RST[TIMING_W-1:0];
         large_page <= 1'b0;
         addr4      <= 1'b0;
         ce_normal  <= CE_NORMAL_RST;
      end else if (armed) begin
         if (hit_tim) begin
            timing_q <= wr_data[TIMING_W-1:0];
         end
         if (hit_if) begin
            large_page <= wr_data[IF_LARGE_BIT];
            addr4      <= wr_data[IF_ADDR4_BIT];
         end
         if (hit_ce) begin
            ce_normal <= wr_data[CE_NORMAL_BIT];
         end
      end
   end

endmodule

// File: rtl/nand_tim_dcnt.sv
module nand_tim_dcnt #(
   parameter int W = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic [W-1:0] cnt
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= load_val;
      end else if (cnt != '0) begin
         cnt <= cnt - W'(1);
      end
   end

endmodule

// File: rtl/nand_tim_seq.sv
module nand_tim_seq
   import nand_tim_pkg::*;
#(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req,
   input  logic             rd,
   input  logic             cmd,
   input  logic             ce_normal,
   input  logic [CNT_W-1:0] wl_eff,
   input  logic [CNT_W-1:0] wh_eff,
   input  logic [CNT_W-1:0] rl_eff,
   input  logic [CNT_W-1:0] rh_eff,
   input  logic [CNT_W-1:0] ta_eff,
   input  logic [CNT_W-1:0] bsy_eff,
   input  logic [CNT_W-1:0] cea_eff,
   output logic             done,
   output logic             we_n,
   output logic             re_n,
   output logic             ce_n,
   output logic             rb_sample
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   tim_state_e       st;
   logic [CNT_W-1:0] cnt;
   logic             rd_q, cmd_q, ce_act;
   logic             acc_rd, need_ta;
   logic [CNT_W-1:0] low_ld, high_ld;
   logic [CNT_W-1:0] ta_left, bsy_left;
   logic             ta_load, bsy_load;

   // Kind of the access being started: live inputs in idle, captured later
   assign acc_rd  = (st == ST_IDLE) ? rd : rd_q;
   assign need_ta = !acc_rd && (ta_left > ONE);
   assign low_ld  = acc_rd ? (rl_eff - ONE) : (wl_eff - ONE);
   assign high_ld = rd_q ? (rh_eff - ONE) : (wh_eff - ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         cnt    <= '0;
         rd_q   <= 1'b0;
         cmd_q  <= 1'b0;
         ce_act <= 1'b0;
      end else begin
         unique case (st)
            ST_IDLE: begin
               if (req) begin
                  rd_q   <= rd;
                  cmd_q  <= cmd && !rd;
                  ce_act <= 1'b1;
                  if (ce_normal && !ce_act) begin
                     st  <= ST_CEA;
                     cnt <= cea_eff - ONE;
                  end else if (need_ta) begin
                     st <= ST_TA;
                  end else begin
                     st  <= ST_LOW;
                     cnt <= low_ld;
                  end
               end else begin
                  ce_act <= 1'b0;
               end
            end
            ST_CEA: begin
               if (cnt != '0) begin
                  cnt <= cnt - ONE;
               end else if (need_ta) begin
                  st <= ST_TA;
               end else begin
                  st  <= ST_LOW;
                  cnt <= low_ld;
               end
            end
            ST_TA: begin
               if (ta_left <= ONE) begin
                  st  <= ST_LOW;
                  cnt <= low_ld;
               end
            end
            ST_LOW: begin
               if (cnt != '0) begin
                  cnt <= cnt - ONE;
               end else begin
                  st  <= ST_HIGH;
                  cnt <= high_ld;
               end
            end
            ST_HIGH: begin
               if (cnt != '0) begin
                  cnt <= cnt - ONE;
               end else begin
                  st <= ST_IDLE;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign done     = (st == ST_HIGH) && (cnt == '0);
   assign ta_load  = done && rd_q;
   assign bsy_load = done && cmd_q;

   nand_tim_dcnt #(.W(CNT_W)) u_ta_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ta_load),
      .load_val (ta_eff),
      .cnt      (ta_left)
   );

   nand_tim_dcnt #(.W(CNT_W)) u_bsy_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (bsy_load),
      .load_val (bsy_eff),
      .cnt      (bsy_left)
   );

   assign we_n      = !((st == ST_LOW) && !rd_q);
   assign re_n      = !((st == ST_LOW) && rd_q);
   assign ce_n      = ce_normal ? !ce_act : 1'b0;
   assign rb_sample = (bsy_left == ONE);

endmodule

// File: rtl/nand_bus_timer.sv
module nand_bus_timer
   import nand_tim_pkg::*;
#(
   parameter int                ADDR_W        = 4,
   parameter int                DATA_W        = 32,
   parameter int                CNT_W         = 5,
   parameter logic [DATA_W-1:0] UNLOCK_KEY    = 32'h0000_A25E,
   parameter logic [DATA_W-1:0] TIMING_RST    = '0,
   parameter bit                CE_NORMAL_RST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic              strb_req,
   input  logic              strb_rd,
   input  logic              strb_cmd,
   output logic              strb_done,
   output logic              nand_we_n,
   output logic              nand_re_n,
   output logic              nand_ce_n,
   output logic              rb_sample,
   output logic              cfg_large_page,
   output logic              cfg_addr4
);

   // Elaboration checks on the parameter set
   if (DATA_W < TIMING_W) begin : g_bad_data_w
      $error("DATA_W must hold the %0d-bit timing word", TIMING_W);
   end
   if (CNT_W < MAX_FLD_W) begin : g_bad_cnt_w
      $error("CNT_W must hold the widest timing field");
   end
   if (ADDR_W < 2) begin : g_bad_addr_w
      $error("ADDR_W must cover four registers");
   end

   logic [TIMING_W-1:0] timing_q;
   logic                ce_normal;
   logic [CNT_W-1:0]    eff [NUM_FLD];
   logic [CNT_W-1:0]    ta_eff;

   nand_tim_regs #(
      .ADDR_W        (ADDR_W),
      .DATA_W        (DATA_W),
      .KEY           (UNLOCK_KEY),
      .TIMING_RST    (TIMING_RST),
      .CE_NORMAL_RST (CE_NORMAL_RST)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (reg_wr),
      .wr_addr    (reg_addr),
      .wr_data    (reg_wdata),
      .timing_q   (timing_q),
      .large_page (cfg_large_page),
      .addr4      (cfg_addr4),
      .ce_normal  (ce_normal)
   );

   // Field unpack: a zero field counts as one cycle (R7)
   for (genvar i = 0; i < NUM_FLD; i++) begin : g_fld
      logic [FLD_WID[i]-1:0] raw;
      assign raw    = timing_q[FLD_LSB[i] +: FLD_WID[i]];
      assign eff[i] = (raw == '0) ? CNT_W'(1) : CNT_W'(raw);
   end

   assign ta_eff = eff[F_TA];

   nand_tim_seq #(.CNT_W(CNT_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (strb_req),
      .rd        (strb_rd),
      .cmd       (strb_cmd),
      .ce_normal (ce_normal),
      .wl_eff    (eff[F_WL]),
      .wh_eff    (eff[F_WH]),
      .rl_eff    (eff[F_RL]),
      .rh_eff    (eff[F_RH]),
      .ta_eff    (ta_eff),
      .bsy_eff   (eff[F_BSY]),
      .cea_eff   (eff[F_CEA]),
      .done      (strb_done),
      .we_n      (nand_we_n),
      .re_n      (nand_re_n),
      .ce_n      (nand_ce_n),
      .rb_sample (rb_sample)
   );

endmodule

// File: rtl/nand_bus_timer_chk.sv
module nand_bus_timer_chk
   import nand_tim_pkg::*;
#(
   parameter int                ADDR_W = 4,
   parameter int                DATA_W = 32,
   parameter int                CNT_W  = 5,
   parameter logic [DATA_W-1:0] KEY    = 32'h0000_A25E
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [DATA_W-1:0] reg_wdata,
   input logic              strb_done,
   input logic              nand_we_n,
   input logic              nand_re_n,
   input logic              nand_ce_n,
   input logic              cfg_large_page,
   input logic              cfg_addr4,
   input logic              ce_normal,
   input logic [CNT_W-1:0]  ta_eff
);

   logic             armed_m, last_rd, seen_rd;
   logic [CNT_W:0]   since;
   logic [CNT_W-1:0] ta_cap;
   logic             is_cfg, is_lock, is_if;

   assign is_lock = reg_wr && (reg_addr == ADDR_W'(A_LOCK));
   assign is_if   = reg_wr && (reg_addr == ADDR_W'(A_IFCFG));
   assign is_cfg  = reg_wr && ((reg_addr == ADDR_W'(A_TIMING)) ||
                               (reg_addr == ADDR_W'(A_IFCFG))  ||
                               (reg_addr == ADDR_W'(A_CECFG)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_m <= 1'b0;
         last_rd <= 1'b0;
         seen_rd <= 1'b0;
         since   <= '0;
         ta_cap  <= '0;
      end else begin
         if (is_lock) begin
            armed_m <= (reg_wdata == KEY);
         end else if (is_cfg) begin
            armed_m <= 1'b0;
         end
         if (!nand_re_n) begin
            last_rd <= 1'b1;
         end else if (!nand_we_n) begin
            last_rd <= 1'b0;
         end
         if (strb_done && last_rd) begin
            since   <= '0;
            ta_cap  <= ta_eff;
            seen_rd <= 1'b1;
         end else if (since != '1) begin
            since <= since + 1'b1;
         end
      end
   end

   assert_locked_cfg_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (is_cfg && !armed_m) |=> ($stable(cfg_large_page) && $stable(cfg_addr4) &&
                                $stable(ce_normal) && $stable(ta_eff)));

   assert_unlocked_apply_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (is_if && armed_m) |=> ((cfg_large_page == $past(reg_wdata[IF_LARGE_BIT])) &&
                              (cfg_addr4 == $past(reg_wdata[IF_ADDR4_BIT]))));

   assert_no_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(!nand_we_n && !nand_re_n));

   assert_done_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
      strb_done |-> (nand_we_n && nand_re_n));

   assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      strb_done |=> !strb_done);

   assert_ce_cover_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!nand_we_n || !nand_re_n) |-> !nand_ce_n);

   assert_forced_ce_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !ce_normal |-> !nand_ce_n);

   assert_turnaround_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_rd && $fell(nand_we_n)) |-> (since >= {1'b0, ta_cap}));

endmodule

bind nand_bus_timer nand_bus_timer_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .CNT_W  (CNT_W),
   .KEY    (UNLOCK_KEY)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .reg_wr         (reg_wr),
   .reg_addr       (reg_addr),
   .reg_wdata      (reg_wdata),
   .strb_done      (strb_done),
   .nand_we_n      (nand_we_n),
   .nand_re_n      (nand_re_n),
   .nand_ce_n      (nand_ce_n),
   .cfg_large_page (cfg_large_page),
   .cfg_addr4      (cfg_addr4),
   .ce_normal      (ce_normal),
   .ta_eff         (ta_eff)
);

// File: tb/tb_nand_bus_timer.sv
`timescale 1ns/1ps
module tb_nand_bus_timer;

   localparam int ADDR_W = 4;
   localparam int DATA_W = 32;
   localparam logic [31:0] KEY = 32'h0000_A25E;
   localparam int A_LOCK = 0, A_TIM = 1, A_IF = 2, A_CE = 3;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              reg_wr = 1'b0;
   logic [ADDR_W-1:0] reg_addr = '0;
   logic [DATA_W-1:0] reg_wdata = '0;
   logic              strb_req = 1'b0;
   logic              strb_rd = 1'b0;
   logic              strb_cmd = 1'b0;
   logic              strb_done, nand_we_n, nand_re_n, nand_ce_n;
   logic              rb_sample, cfg_large_page, cfg_addr4;

   int  errors = 0;
   int  checks = 0;
   bit  finished = 1'b0;

   always #2.5 clk = ~clk;

   nand_bus_timer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
      .clk            (clk),
      .rst_n          (rst_n),
      .reg_wr         (reg_wr),
      .reg_addr       (reg_addr),
      .reg_wdata      (reg_wdata),
      .strb_req       (strb_req),
      .strb_rd        (strb_rd),
      .strb_cmd       (strb_cmd),
      .strb_done      (strb_done),
      .nand_we_n      (nand_we_n),
      .nand_re_n      (nand_re_n),
      .nand_ce_n      (nand_ce_n),
      .rb_sample      (rb_sample),
      .cfg_large_page (cfg_large_page),
      .cfg_addr4      (cfg_addr4)
   );

   typedef struct packed {
      logic [31:0] word;
      logic        rd;
      logic [7:0]  pre;
      logic [7:0]  lo;
      logic [7:0]  hi;
   } vec_t;

   // Cold-start strobes: pre = chip-enable lead-in, lo/hi = phase lengths
   localparam vec_t VECS [5] = '{
      '{32'h0100_0023, 1'b0, 8'd1, 8'd3,  8'd2 },   // R5 write 3/2, R8 cea 1
      '{32'h0100_0023, 1'b1, 8'd1, 8'd1,  8'd1 },   // R6 R7 read fields zero
      '{32'h0300_00FF, 1'b0, 8'd3, 8'd15, 8'd15},   // R5 R12 largest write fields
      '{32'h0200_4500, 1'b1, 8'd2, 8'd5,  8'd4 },   // R6 R12 read 5/4, cea 2
      '{32'h0000_0011, 1'b0, 8'd1, 8'd1,  8'd1 }    // R7 cea zero gives one
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wr_reg(input int addr, input logic [31:0] data);
      reg_wr    = 1'b1;
      reg_addr  = ADDR_W'(addr);
      reg_wdata = data;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic prog(input int addr, input logic [31:0] data);
      wr_reg(A_LOCK, KEY);
      wr_reg(addr, data);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // Starts at a negedge, holds req until done, returns at the done negedge
   task automatic run_strobe(input logic rd, input logic cmd,
                             output int pre, output int lo, output int hi);
      int   phase;
      bit   fin;
      logic s;
      strb_req = 1'b1;
      strb_rd  = rd;
      strb_cmd = cmd;
      pre = 0; lo = 0; hi = 0; phase = 0; fin = 1'b0;
      for (int k = 0; k < 300 && !fin; k++) begin
         @(negedge clk);
         s = rd ? nand_re_n : nand_we_n;
         if (phase == 0) begin
            if (!s) begin phase = 1; lo++; end
            else pre++;
         end else if (phase == 1) begin
            if (!s) lo++;
            else begin phase = 2; hi++; fin = strb_done; end
         end else begin
            hi++;
            fin = strb_done;
         end
      end
      strb_req = 1'b0;
      strb_cmd = 1'b0;
      if (!fin) begin
         errors++;
         checks++;
         $display("FAIL R5: actual=no done expected=done within 300 cycles");
      end
   endtask

   initial begin
      repeat (60000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int pre, lo, hi, wait_k, rb_cnt;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state {we,re,ce,done,rb,large,addr4}
      chk("R1 reset outputs",
          {nand_we_n, nand_re_n, nand_ce_n, strb_done, rb_sample, cfg_large_page, cfg_addr4},
          32'b1110000);

      // R2 locked write ignored
      wr_reg(A_IF, 32'h6);
      @(negedge clk);
      chk("R2 locked interface write", {cfg_large_page, cfg_addr4}, 2'b00);

      // R3 key then write applies (bit 2 large page, bit 1 four address cycles)
      prog(A_IF, 32'h6);
      chk("R3 unlocked interface write", {cfg_large_page, cfg_addr4}, 2'b11);

      // R4 one-shot: second write refused
      wr_reg(A_IF, 32'h0);
      chk("R4 second write after one key", {cfg_large_page, cfg_addr4}, 2'b11);
      // R4 wrong key disarms
      wr_reg(A_LOCK, 32'h0000_A25F);
      wr_reg(A_IF, 32'h0);
      chk("R4 wrong key", {cfg_large_page, cfg_addr4}, 2'b11);
      // R12 bit positions: bit 1 only
      prog(A_IF, 32'h2);
      chk("R12 interface bit positions", {cfg_large_page, cfg_addr4}, 2'b01);

      // Table walk: cold strobes (R5 R6 R7 R8 R12)
      for (int i = 0; i < 5; i++) begin
         prog(A_TIM, VECS[i].word);
         idle(10);
         run_strobe(VECS[i].rd, 1'b0, pre, lo, hi);
         chk($sformatf("R8 vec%0d lead-in", i), pre, VECS[i].pre);
         chk($sformatf("R5 R6 vec%0d low", i), lo, VECS[i].lo);
         chk($sformatf("R5 R6 vec%0d high", i), hi, VECS[i].hi);
         if (i == 0) begin
            idle(3);
            chk("R8 ce released when idle", nand_ce_n, 1'b1);
         end
      end

      // R2 timing write without key: write strobe keeps 1/1
      wr_reg(A_TIM, 32'h0000_0014);
      idle(10);
      run_strobe(1'b0, 1'b0, pre, lo, hi);
      chk("R2 locked timing write low", lo, 1);

      // R10 turnaround 5
      prog(A_TIM, 32'h0105_1111);
      idle(10);
      run_strobe(1'b1, 1'b0, pre, lo, hi);
      run_strobe(1'b0, 1'b0, pre, lo, hi);
      chk("R10 read-to-write gap", pre, 5);
      chk("R10 write low after gap", lo, 1);
      run_strobe(1'b0, 1'b0, pre, lo, hi);
      chk("R10 write-to-write gap", pre, 1);
      run_strobe(1'b1, 1'b0, pre, lo, hi);
      chk("R10 write-to-read gap", pre, 1);

      // R11 busy sample 6 cycles after command write done
      prog(A_TIM, 32'h0130_1111);
      idle(10);
      run_strobe(1'b0, 1'b1, pre, lo, hi);
      wait_k = 0;
      for (int k = 1; k <= 40 && wait_k == 0; k++) begin
         @(negedge clk);
         if (rb_sample) wait_k = k;
      end
      chk("R11 command busy delay", wait_k, 6);
      idle(10);
      run_strobe(1'b0, 1'b0, pre, lo, hi);
      rb_cnt = 0;
      for (int k = 0; k < 40; k++) begin
         @(negedge clk);
         if (rb_sample) rb_cnt++;
      end
      chk("R11 plain write no sample", rb_cnt, 0);
      run_strobe(1'b1, 1'b1, pre, lo, hi);
      rb_cnt = 0;
      for (int k = 0; k < 40; k++) begin
         @(negedge clk);
         if (rb_sample) rb_cnt++;
      end
      chk("R11 read with cmd no sample", rb_cnt, 0);

      // R9 forced chip enable, no lead-in even with cea 3
      prog(A_TIM, 32'h0300_0011);
      prog(A_CE, 32'h0);
      idle(3);
      chk("R9 ce held low idle", nand_ce_n, 1'b0);
      run_strobe(1'b0, 1'b0, pre, lo, hi);
      chk("R9 forced ce lead-in", pre, 0);
      prog(A_CE, 32'h1);
      idle(3);
      chk("R8 normal ce restored", nand_ce_n, 1'b1);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule